// File: doc/BRIEF.md
# Interrupt Controller Countdown Timer

This block is the countdown timer of a per-core interrupt controller. Software programs it through a small register window. The window holds four registers: a reload value, the live count, a divider setting and a local vector entry. The timer is paced by a processor-clock enable pulse that a power-of-two prescaler divides down. Each divided tick lowers the live count by one. When the count runs out, the timer sends the vector held in its entry to the interrupt request tracker as a one-cycle request, unless software has masked the entry.

Two modes are supported. In one-shot mode the timer stops and stays at zero after it expires. In periodic mode it reloads the reload value and keeps counting. A reload value of zero halts the timer completely. A divider setting that is not legal freezes the count and raises an error flag.

Top module: `lic_countdown_timer`

## Requirements
- R1: After reset the reload and live counts read 0, the divider register reads 0, the vector entry reads 0x00010000 (masked, one-shot, vector 0) and no request is presented.
- R2: A write to the reload-count register (address 0) loads the written value into both the reload count and the live count.
- R3: While `reg_rd` is high, `reg_rdata` shows the addressed register in that same cycle, and the live count (address 1) is shown as it currently stands. While `reg_rd` is low, `reg_rdata` is 0.
- R4: Divider values 0 to 7 (address 2, bits 3:0) give one tick for every 2^n processor-clock enables, which covers divide-by-16, 32, 64 and 128. Each tick lowers the live count by one. A write to address 0, 1 or 2 restarts the prescaler, so the first tick comes on the 2^n-th enable after the write.
- R5: While the reload count is zero, the live count does not change and no request is made.
- R6: In one-shot mode (entry bit 17 = 0), the tick that takes the count from 1 to 0 is an expiry. After that the count stays at 0 and no further requests are made.
- R7: In periodic mode (entry bit 17 = 1), an expiry reloads the live count with the reload count and counting continues. After k ticks from a load of N, the count is N - (k mod N), and floor(k/N) expiries have occurred.
- R8: When entry bit 16 (mask) is set, expiries make no request. The count still runs and reloads as it would without the mask.
- R9: Each expiry raises `irq_req_valid` for exactly one clock, in the cycle after the expiring tick, with `irq_req_vector` equal to entry bits 7:0.
- R10: Divider values 8 to 15 hold the live count and the prescaler, and drive `div_err` high. Writing a legal value clears `div_err` and counting resumes.
- R11: A write to the live-count register (address 1) changes only the live count and leaves the reload count as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | Processor-clock enable, one pulse per processor cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 reload, 1 live count, 2 divider, 3 vector entry |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational with `reg_rd` |
| irq_req_valid | output | 1 | One-cycle vector request to the request tracker |
| irq_req_vector | output | 8 | Vector that goes with the request |
| div_err | output | 1 | The stored divider value is not legal |

## Verification
Directed cases try the timer with a zero reload count, an illegal divider, a masked periodic entry and a one-shot entry that runs past zero. Each of these separates "count frozen" from "count running without a request" from "count stuck at zero". Divide-by-1, by-4 and by-16 runs with enable counts that are not multiples of the divisor show whether the prescaler restarts on a write and rounds down. Random runs combine reload values, dividers, modes and random gaps between enables. Each run checks the live count and the number of request pulses against a closed-form formula. A model that counts enables in place of ticks, loses a reload, or emits a pulse longer than one cycle fails those formulas.

// File: rtl/lct_pkg.sv
package lct_pkg;

  localparam int CNT_W      = 32;
  localparam int VEC_W      = 8;
  localparam int DIV_CFG_W  = 4;
  localparam int SHIFT_W    = 3;
  localparam int PRE_W      = (1 << SHIFT_W) - 1;
  localparam int ADDR_W     = 2;

  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd0;
  localparam logic [ADDR_W-1:0] A_LIVE   = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIV    = 2'd2;
  localparam logic [ADDR_W-1:0] A_ENTRY  = 2'd3;

  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;

  typedef struct packed {
    logic             legal;
    logic [SHIFT_W-1:0] shift;
  } div_dec_t;

  typedef struct packed {
    logic [CNT_W-1:0] next;
    logic             expire;
  } step_t;

  function automatic div_dec_t decode_div(input logic [DIV_CFG_W-1:0] cfg);
    div_dec_t d;
    d.legal = (cfg < DIV_CFG_W'(1 << SHIFT_W));
    d.shift = cfg[SHIFT_W-1:0];
    return d;
  endfunction

  function automatic logic [PRE_W-1:0] shift_mask(input logic [SHIFT_W-1:0] sh);
    logic [PRE_W:0] one_hot;
    one_hot = (PRE_W+1)'(1) << sh;
    return PRE_W'(one_hot - 1'b1);
  endfunction

  function automatic step_t count_step(input logic [CNT_W-1:0] live,
                                       input logic [CNT_W-1:0] reload,
                                       input logic             periodic);
    step_t s;
    if (live <= CNT_W'(1)) begin
      s.expire = 1'b1;
      s.next   = periodic ? reload : '0;
    end else begin
      s.expire = 1'b0;
      s.next   = live - 1'b1;
    end
    return s;
  endfunction

endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler
  import lct_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic               restart,
  input  logic               run,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] msk;

  assign msk  = shift_mask(shift);
  assign tick = ce && run && !restart && ((pre_q & msk) == msk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (ce && run) begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/lct_down_counter.sv
module lct_down_counter
  import lct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_reload,
  input  logic             load_live,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] live_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             expire
);

  logic  active;
  step_t step;

  assign active = (reload_q != '0) && !(!periodic && live_q == '0);
  assign step   = count_step(live_q, reload_q, periodic);
  assign expire = tick && active && !load_reload && !load_live && step.expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q   <= '0;
      reload_q <= '0;
    end else if (load_reload) begin
      reload_q <= wdata;
      live_q   <= wdata;
    end else if (load_live) begin
      live_q   <= wdata;
    end else if (tick && active) begin
      live_q   <= step.next;
    end
  end

endmodule

// File: rtl/lct_regfile.sv
module lct_regfile
  import lct_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [CNT_W-1:0]     reg_wdata,
  input  logic [CNT_W-1:0]     live,
  input  logic [CNT_W-1:0]     reload,
  output logic [CNT_W-1:0]     reg_rdata,
  output logic                 wr_reload,
  output logic                 wr_live,
  output logic                 wr_div,
  output logic [DIV_CFG_W-1:0] div_cfg,
  output logic [VEC_W-1:0]     vec,
  output logic                 masked,
  output logic                 periodic
);

  logic             wr_entry;
  logic [CNT_W-1:0] entry_view;

  assign wr_reload = reg_wr && (reg_addr == A_RELOAD);
  assign wr_live   = reg_wr && (reg_addr == A_LIVE);
  assign wr_div    = reg_wr && (reg_addr == A_DIV);
  assign wr_entry  = reg_wr && (reg_addr == A_ENTRY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cfg  <= '0;
      vec      <= '0;
      masked   <= 1'b1;
      periodic <= 1'b0;
    end else begin
      if (wr_div) div_cfg <= reg_wdata[DIV_CFG_W-1:0];
      if (wr_entry) begin
        vec      <= reg_wdata[VEC_W-1:0];
        masked   <= reg_wdata[MASK_BIT];
        periodic <= reg_wdata[MODE_BIT];
      end
    end
  end

  always_comb begin
    entry_view                = '0;
    entry_view[VEC_W-1:0]     = vec;
    entry_view[MASK_BIT]      = masked;
    entry_view[MODE_BIT]      = periodic;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        A_RELOAD: reg_rdata = reload;
        A_LIVE:   reg_rdata = live;
        A_DIV:    reg_rdata = CNT_W'(div_cfg);
        A_ENTRY:  reg_rdata = entry_view;
        default:  reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/lic_countdown_timer.sv
module lic_countdown_timer
  import lct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ce,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_req_valid,
  output logic [7:0]        irq_req_vector,
  output logic              div_err
);

  logic                 wr_reload, wr_live, wr_div;
  logic [DIV_CFG_W-1:0] div_cfg;
  logic [VEC_W-1:0]     vec;
  logic                 masked, periodic;
  logic [CNT_W-1:0]     live_count, reload_count;
  logic                 tick, expire;
  div_dec_t             dec;

  assign dec     = decode_div(div_cfg);
  assign div_err = !dec.legal;

  lct_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .live      (live_count),
    .reload    (reload_count),
    .reg_rdata (reg_rdata),
    .wr_reload (wr_reload),
    .wr_live   (wr_live),
    .wr_div    (wr_div),
    .div_cfg   (div_cfg),
    .vec       (vec),
    .masked    (masked),
    .periodic  (periodic)
  );

  lct_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (cpu_ce),
    .restart (wr_reload || wr_live || wr_div),
    .run     (dec.legal),
    .shift   (dec.shift),
    .tick    (tick)
  );

  lct_down_counter u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_reload (wr_reload),
    .load_live   (wr_live),
    .wdata       (reg_wdata),
    .tick        (tick),
    .periodic    (periodic),
    .live_q      (live_count),
    .reload_q    (reload_count),
    .expire      (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req_valid  <= 1'b0;
      irq_req_vector <= '0;
    end else begin
      irq_req_valid  <= expire && !masked;
      irq_req_vector <= (expire && !masked) ? vec : '0;
    end
  end

endmodule

// File: rtl/lct_checker.sv
module lct_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_ce,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] live,
  input logic [31:0] reload,
  input logic        tick,
  input logic        expire,
  input logic        masked,
  input logic        periodic,
  input logic        div_err,
  input logic        irq_req_valid
);

  a_r2_reload_loads_live: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (live == $past(reg_wdata) && reload == $past(reg_wdata)));

  a_r4_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ce |-> !tick);

  a_r5_zero_reload_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (reload == '0) |-> !expire);

  a_r6_oneshot_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && live == '0 && !reg_wr) |=> (live == '0));

  a_r7_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (live == reload));

  a_r8_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(masked) |-> !irq_req_valid);

  a_r9_request_follows_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_valid |-> $past(expire));

  a_r10_bad_divider_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (div_err && !reg_wr) |=> $stable(live));

endmodule

bind lic_countdown_timer lct_checker u_lct_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_ce        (cpu_ce),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .live          (live_count),
  .reload        (reload_count),
  .tick          (tick),
  .expire        (expire),
  .masked        (masked),
  .periodic      (periodic),
  .div_err       (div_err),
  .irq_req_valid (irq_req_valid)
);

// File: tb/lic_countdown_timer_tb_top.sv
module lic_countdown_timer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_ce = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req_valid;
  logic [7:0]  irq_req_vector;
  logic        div_err;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  logic [7:0] last_vec = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lic_countdown_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req_valid(irq_req_valid), .irq_req_vector(irq_req_vector), .div_err(div_err)
  );

  always @(negedge clk) begin
    if (rst_n && irq_req_valid) begin
      pulses++;
      last_vec = irq_req_vector;
    end
  end

  function automatic int exp_live(int n, int k, bit per);
    if (per) return (k == 0) ? n : n - (k % n);
    return (k >= n) ? 0 : n - k;
  endfunction

  function automatic int exp_pulses(int n, int k, bit per);
    if (per) return k / n;
    return (k >= n) ? 1 : 0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic run_ce(int n, int max_gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_ce = 1'b1;
      if (max_gap > 0) begin
        int g = $urandom_range(max_gap, 0);
        if (g > 0) begin
          @(negedge clk);
          cpu_ce = 1'b0;
          repeat (g - 1) @(negedge clk);
        end
      end
    end
    @(negedge clk);
    cpu_ce = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int p0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 reload", v, 0);
    rd(2'd1, v); check("R1 live", v, 0);
    rd(2'd2, v); check("R1 div", v, 0);
    rd(2'd3, v); check("R1 entry", v, 32'h0001_0000);
    check("R1 no request", {31'd0, irq_req_valid}, 0);

    // R2 reload write loads live; R3 rdata zero when not reading
    wr(2'd0, 32'd5);
    rd(2'd1, v); check("R2 live loaded", v, 5);
    @(negedge clk); #1 check("R3 idle rdata", reg_rdata, 0);

    // R11 live write keeps reload
    wr(2'd1, 32'd3);
    rd(2'd1, v); check("R11 live", v, 3);
    rd(2'd0, v); check("R11 reload kept", v, 5);

    // R4 divide by 1, 4, 16; R3 live read
    wr(2'd3, 32'h0000_0042);
    wr(2'd2, 32'd0);
    wr(2'd0, 32'd10);
    run_ce(4, 0);
    rd(2'd1, v); check("R4 R3 div1 live", v, 6);
    wr(2'd2, 32'd2);
    run_ce(9, 0);
    rd(2'd1, v); check("R4 div4", v, 4);
    wr(2'd2, 32'd4);
    wr(2'd0, 32'd100);
    run_ce(33, 0);
    rd(2'd1, v); check("R4 div16", v, 98);

    // R6 one-shot expiry, R9 single pulse with vector
    wr(2'd2, 32'd0);
    p0 = pulses;
    wr(2'd0, 32'd3);
    run_ce(3, 0);
    check("R9 one pulse", pulses - p0, 1);
    check("R9 vector", {24'd0, last_vec}, 32'h42);
    rd(2'd1, v); check("R6 at zero", v, 0);
    run_ce(5, 0);
    check("R6 no more requests", pulses - p0, 1);
    rd(2'd1, v); check("R6 parked", v, 0);

    // R7 periodic
    wr(2'd3, 32'h0002_0055);
    p0 = pulses;
    wr(2'd0, 32'd4);
    run_ce(10, 0);
    check("R7 expiries", pulses - p0, 2);
    check("R7 R9 vector", {24'd0, last_vec}, 32'h55);
    rd(2'd1, v); check("R7 live", v, 2);

    // R8 masked periodic
    wr(2'd3, 32'h0003_0055);
    p0 = pulses;
    wr(2'd0, 32'd3);
    run_ce(7, 0);
    check("R8 no request", pulses - p0, 0);
    rd(2'd1, v); check("R8 still reloads", v, 2);

    // R5 zero reload
    wr(2'd3, 32'h0002_0011);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd5);
    p0 = pulses;
    run_ce(10, 0);
    rd(2'd1, v); check("R5 frozen", v, 5);
    check("R5 no request", pulses - p0, 0);

    // R10 illegal divider
    wr(2'd2, 32'd9);
    check("R10 err high", {31'd0, div_err}, 1);
    wr(2'd0, 32'd5);
    run_ce(8, 0);
    rd(2'd1, v); check("R10 hold", v, 5);
    wr(2'd2, 32'd0);
    check("R10 err clear", {31'd0, div_err}, 0);
    run_ce(2, 0);
    rd(2'd1, v); check("R10 resume", v, 3);

    // Random runs: R4 R6 R7 R9
    for (int it = 0; it < 24; it++) begin
      int sh  = $urandom_range(3, 0);
      bit per = 1'($urandom_range(1, 0));
      int n   = $urandom_range(20, 1);
      int ce  = $urandom_range(80, 0);
      int k;
      logic [7:0] vv = 8'($urandom);
      wr(2'd3, {14'd0, per, 1'b0, 8'd0, vv});
      wr(2'd2, 32'(sh));
      p0 = pulses;
      wr(2'd0, 32'(n));
      run_ce(ce, 3);
      k = ce >> sh;
      rd(2'd1, v); check(per ? "R7 rand live" : "R6 rand live", v, 32'(exp_live(n, k, per)));
      check("R4 R9 rand pulses", 32'(pulses - p0), 32'(exp_pulses(n, k, per)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule